// File: doc/BRIEF.md
# Low-Power Oscillator Mode Controller

This block chooses how a 32 kHz crystal oscillator is driven: a quiet, low-power drive or a noise-immune drive. The choice comes from a 2-bit mode setting and from the processor's power state. The block also decides what happens when the processor leaves stop mode. Either execution is released at once, or the release is held back until an externally measured oscillator warm-up period has finished.

The processor signals entry into stop with a level (`stop_i`) and asks to leave with a one-cycle request (`exit_req_i`). A separate timer measures the warm-up. The block starts that timer with `wu_start_o` and learns that it is done through the strobe `wu_done_i`. The `release_o` output is high whenever code may run.

Top module: `osc_lp_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is in its run state with release_o=1, quiet_o=0 (noise-immune drive), wu_start_o=0, and the latched mode is 0.
- R2: With latched mode 0, quiet_o stays 0 in every power state, including stop.
- R3: With latched mode 1, quiet_o stays 1 in every power state. A stop exit raises release_o on the following cycle and never pulses wu_start_o.
- R4: With latched mode 2 or 3, quiet_o is 0 while running and 1 while in stop.
- R5: With latched mode 2, an exit request during stop gives wu_start_o high for exactly one cycle, starting on the next cycle. release_o stays 0 and quiet_o is 0 until wu_done_i is seen. release_o rises on the cycle after that strobe.
- R6: With latched mode 3, an exit request during stop raises release_o on the next cycle and never pulses wu_start_o.
- R7: mode_i is latched only while running with stop_i low, one cycle after it is presented. A value written during stop or warm-up wait is ignored until release, and is then picked up if still present.
- R8: wu_done_i is ignored outside the warm-up wait. exit_req_i is ignored while running.
- R9: stop_i high while running drops release_o on the next cycle and enters stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Oscillator mode setting (0 to 3) |
| stop_i | input | 1 | Processor requests stop/deep-sleep (level) |
| exit_req_i | input | 1 | Stop-exit request (one cycle) |
| wu_done_i | input | 1 | Warm-up finished strobe |
| quiet_o | output | 1 | 1 = quiet drive, 0 = noise-immune drive |
| wu_start_o | output | 1 | One-cycle warm-up start pulse |
| release_o | output | 1 | Code execution may run |

## Verification
The bench writes a new mode while the block is in stop and again while it waits for warm-up. A design that latched mode_i at those times would skip or wrongly demand a warm-up, or would change the drive while stopped. It sends stray warm-up-done strobes and exit requests while running, which a loose design would take as state changes. It checks that the warm-up start is one cycle wide and that release in mode 3 comes with no pulse. Off-by-one release timing, or a pulse in the wrong mode, shows up as a mismatch at a fixed cycle.

// File: rtl/osc_mode_pkg.sv
// Package: shared widths, mode codes and power-state encoding for the
// oscillator mode controller. Assumes a 2-bit mode setting.
package osc_mode_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NOISE  = 2'd0,
        MODE_QUIET  = 2'd1,
        MODE_TRACKW = 2'd2,
        MODE_TRACKF = 2'd3
    } osc_mode_e;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_STOP = 2'd1,
        PS_WAIT = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/osc_mode_latch.sv
// Module: holds the mode setting in effect. It loads the new value only
// while the processor runs and is not asking to stop. Assumes mode_i is
// stable when sampled.
module osc_mode_latch
    import osc_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  pwr_state_e        state_i,
    input  logic              stop_i,
    output osc_mode_e         mode_o
);
    logic load_en;

    // Purpose: a load is allowed only in the run state with no stop request.
    always_comb load_en = (state_i == PS_RUN) && !stop_i;

    // Purpose: register the effective mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_o <= MODE_NOISE;
        else if (load_en) mode_o <= osc_mode_e'(mode_i);
    end

    // R7: the mode cannot move while stopped or waiting.
    p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != PS_RUN) |=> $stable(mode_o));
endmodule

// File: rtl/osc_power_fsm.sv
// Module: tracks run, stop and warm-up wait. It issues the warm-up start
// pulse and gives the release level. Assumes exit_req_i and wu_done_i are
// single-cycle strobes.
module osc_power_fsm
    import osc_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  osc_mode_e  mode_i,
    input  logic       stop_i,
    input  logic       exit_req_i,
    input  logic       wu_done_i,
    output pwr_state_e state_o,
    output logic       wu_start_o,
    output logic       release_o
);
    pwr_state_e nxt;
    logic       need_wu;
    logic       exit_hit;

    // Purpose: only the waiting-exit mode needs warm-up before release.
    always_comb need_wu = (mode_i == MODE_TRACKW);
    // Purpose: an exit request counts only while in stop.
    always_comb exit_hit = (state_o == PS_STOP) && exit_req_i;

    // Purpose: next-state decision.
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            PS_RUN:  if (stop_i)    nxt = PS_STOP;
            PS_STOP: if (exit_req_i) nxt = need_wu ? PS_WAIT : PS_RUN;
            PS_WAIT: if (wu_done_i) nxt = PS_RUN;
            default:                nxt = PS_RUN;
        endcase
    end

    // Purpose: state register and warm-up start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o    <= PS_RUN;
            wu_start_o <= 1'b0;
        end else begin
            state_o    <= nxt;
            wu_start_o <= exit_hit && need_wu;
        end
    end

    // Purpose: execution may run only in the run state.
    always_comb release_o = (state_o == PS_RUN);

    // R5: the warm-up start is a single cycle wide.
    p_wu_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wu_start_o |=> !wu_start_o);
    // R5: the wait holds until the done strobe.
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_WAIT && !wu_done_i) |=> !release_o);
    // R6: exit without warm-up releases on the next cycle.
    p_fast_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_hit && mode_i != MODE_TRACKW) |=> (release_o && !wu_start_o));
    // R9: a stop request while running drops release.
    p_stop_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_RUN && stop_i) |=> !release_o);
endmodule

// File: rtl/osc_drive_sel.sv
// Module: works out the oscillator drive (quiet or noise-immune) from the
// effective mode and the power state. Pure decode with no state.
module osc_drive_sel
    import osc_mode_pkg::*;
(
    input  osc_mode_e  mode_i,
    input  pwr_state_e state_i,
    output logic       quiet_o
);
    // Purpose: map mode and power state onto the drive select.
    always_comb begin
        unique case (mode_i)
            MODE_NOISE:  quiet_o = 1'b0;
            MODE_QUIET:  quiet_o = 1'b1;
            default:     quiet_o = (state_i == PS_STOP);
        endcase
    end
endmodule

// File: rtl/osc_lp_mode_ctrl.sv
// Module: top of the low-power oscillator mode controller. It joins the
// mode latch, the power FSM and the drive decode. Assumes a single clock
// and synchronous active-low reset.
module osc_lp_mode_ctrl
    import osc_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              stop_i,
    input  logic              exit_req_i,
    input  logic              wu_done_i,
    output logic              quiet_o,
    output logic              wu_start_o,
    output logic              release_o
);
    osc_mode_e  mode_eff;
    pwr_state_e pstate;

    osc_mode_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .state_i (pstate),
        .stop_i  (stop_i),
        .mode_o  (mode_eff)
    );

    osc_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_eff),
        .stop_i     (stop_i),
        .exit_req_i (exit_req_i),
        .wu_done_i  (wu_done_i),
        .state_o    (pstate),
        .wu_start_o (wu_start_o),
        .release_o  (release_o)
    );

    osc_drive_sel u_drv (
        .mode_i  (mode_eff),
        .state_i (pstate),
        .quiet_o (quiet_o)
    );

    // R2: mode 0 never selects the quiet drive.
    p_noise_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_NOISE) |-> !quiet_o);
    // R4: while released, a tracking mode drives noise-immune.
    p_track_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff[1] && release_o) |-> !quiet_o);
endmodule

// File: tb/sim_osc_lp_mode_ctrl.sv
module sim_osc_lp_mode_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       stop_i = 1'b0;
    logic       exit_req_i = 1'b0;
    logic       wu_done_i = 1'b0;
    logic       quiet_o, wu_start_o, release_o;

    int n_chk = 0;
    int n_bad = 0;

    osc_lp_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stop_i(stop_i),
        .exit_req_i(exit_req_i), .wu_done_i(wu_done_i),
        .quiet_o(quiet_o), .wu_start_o(wu_start_o), .release_o(release_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Inputs change at negedge; outputs are sampled at the following negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i = m; tick();
    endtask

    task automatic go_stop();
        stop_i = 1'b1; tick();
    endtask

    task automatic pulse_exit();
        stop_i = 1'b0; exit_req_i = 1'b1; tick(); exit_req_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_i = 2'd3; tick(); tick(); rst_n = 1'b1;
        mode_i = 2'd0;
        chk("R1", "release", release_o, 1'b1);
        chk("R1", "quiet", quiet_o, 1'b0);
        chk("R1", "wu_start", wu_start_o, 1'b0);
        tick();
        go_stop();
        chk("R1", "quiet in stop, mode 0", quiet_o, 1'b0);
        pulse_exit();
        chk("R1", "release after exit", release_o, 1'b1);
    endtask

    task automatic t_mode0();
        set_mode(2'd0);
        chk("R2", "quiet run", quiet_o, 1'b0);
        go_stop();
        chk("R2", "quiet stop", quiet_o, 1'b0);
        chk("R9", "release dropped", release_o, 1'b0);
        pulse_exit();
        chk("R2", "release", release_o, 1'b1);
    endtask

    task automatic t_mode1();
        set_mode(2'd1);
        chk("R3", "quiet run", quiet_o, 1'b1);
        go_stop();
        chk("R3", "quiet stop", quiet_o, 1'b1);
        pulse_exit();
        chk("R3", "release next cycle", release_o, 1'b1);
        chk("R3", "no wu_start", wu_start_o, 1'b0);
    endtask

    task automatic t_mode3();
        set_mode(2'd3);
        chk("R4", "mode3 quiet run", quiet_o, 1'b0);
        go_stop();
        chk("R4", "mode3 quiet stop", quiet_o, 1'b1);
        pulse_exit();
        chk("R6", "release next cycle", release_o, 1'b1);
        chk("R6", "no wu_start", wu_start_o, 1'b0);
        chk("R4", "quiet back off", quiet_o, 1'b0);
    endtask

    task automatic t_mode2();
        set_mode(2'd2);
        chk("R4", "mode2 quiet run", quiet_o, 1'b0);
        go_stop();
        chk("R4", "mode2 quiet stop", quiet_o, 1'b1);
        pulse_exit();
        chk("R5", "wu_start high", wu_start_o, 1'b1);
        chk("R5", "release held", release_o, 1'b0);
        chk("R5", "noise drive in wait", quiet_o, 1'b0);
        tick(); tick();
        chk("R5", "wu_start one cycle", wu_start_o, 1'b0);
        chk("R5", "still held", release_o, 1'b0);
        wu_done_i = 1'b1; tick(); wu_done_i = 1'b0;
        chk("R5", "release after done", release_o, 1'b1);
    endtask

    task automatic t_mode_write_frozen();
        set_mode(2'd2);
        go_stop();
        mode_i = 2'd0; tick();
        chk("R7", "mode write in stop ignored (quiet)", quiet_o, 1'b1);
        pulse_exit();
        chk("R7", "old mode needs warm-up", wu_start_o, 1'b1);
        mode_i = 2'd1; tick();
        chk("R7", "write in wait ignored", quiet_o, 1'b0);
        chk("R7", "still waiting", release_o, 1'b0);
        mode_i = 2'd0;
        wu_done_i = 1'b1; tick(); wu_done_i = 1'b0;
        chk("R7", "released", release_o, 1'b1);
        tick();
        go_stop();
        chk("R7", "mode 0 picked up after release", quiet_o, 1'b0);
        pulse_exit();
        chk("R7", "no warm-up in new mode", wu_start_o, 1'b0);
        chk("R7", "immediate release", release_o, 1'b1);
    endtask

    task automatic t_stray();
        set_mode(2'd2);
        wu_done_i = 1'b1; exit_req_i = 1'b1; tick();
        wu_done_i = 1'b0; exit_req_i = 1'b0;
        chk("R8", "stray strobes keep release", release_o, 1'b1);
        chk("R8", "stray strobes no pulse", wu_start_o, 1'b0);
        go_stop();
        wu_done_i = 1'b1; tick(); wu_done_i = 1'b0;
        chk("R8", "done in stop ignored", release_o, 1'b0);
        chk("R8", "still stopped quiet", quiet_o, 1'b1);
        pulse_exit();
        chk("R8", "wait entered", wu_start_o, 1'b1);
        wu_done_i = 1'b1; tick(); wu_done_i = 1'b0;
        chk("R8", "released", release_o, 1'b1);
    endtask

    initial begin
        tick();
        t_reset();
        t_mode0();
        t_mode1();
        t_mode3();
        t_mode2();
        t_mode_write_frozen();
        t_stray();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule